// File: doc/BRIEF.md
# PDM Control-Pattern Detector

This block sits on the single-bit pulse-density audio stream and looks for in-band commands. A command is an 8-bit byte that the source repeats back to back in place of audio. When the same command byte has been seen on enough consecutive aligned byte windows, the block writes it into a small settings register. The register holds the output gain, the sample-rate selection, three mode flags and a stop indication.

The data line carries two interleaved channels. A select input picks the slot that the block listens to. The rising-edge slot is the left channel and the falling-edge slot is the right channel.

While a command run is in progress the block raises a mute output, so that downstream audio logic can silence the amplifier while settings change. The mute stays up for one byte after the run ends. A reset, which the surrounding power control issues when the bit clock is lost, returns every setting to the strapped defaults. The gain strap and the rate strap are static inputs.

Top module: `pdm_pattern_detector`

## Requirements
- R1: A command takes effect only on its 128th consecutive aligned repeat. After 127 repeats every setting output still shows its prior value.
- R2: Byte 0xD8 sets gain_sel to 2'b00 (5 V). 0xD4 sets it to 2'b01 (3.6 V). 0xD2 sets it to 2'b10 (2.5 V). These codes override the strap. Until such a code takes effect, gain_sel is 2'b00 when strap_gain is 0 and 2'b01 when strap_gain is 1.
- R3: Byte 0xD1 drives rate_sel to the inverse of strap_rate, where 0 means 64x and 1 means 128x. A second full run of 0xD1 leaves rate_sel inverted and does not toggle it back.
- R4: Byte 0xE1 sets low_emi, 0xE2 sets half_pulse and 0xE4 sets special_rate. Each flag stays set until reset.
- R5: Byte 0xAC raises stop_flag on its 128th repeat. stop_flag falls at the first byte boundary whose byte is not 0xAC.
- R6: With lr_sel high, the bit sampled on the falling clock edge is decoded. With lr_sel low, the bit sampled on the rising edge is decoded. The other slot has no effect.
- R7: mute rises with the 8th consecutive aligned repeat of a command. It stays high for the rest of the run and for 7 more bits after the byte that ends the run. It falls on the 8th bit after that byte.
- R8: The byte window locks to the first bit position where a command matches, at any offset. At each later 8th bit the new byte is compared with the command. A non-matching byte clears the count. If that byte is itself a command, a new run starts with a count of one.
- R9: An active-low reset, asserted asynchronously and released through a two-stage synchronizer, restores all settings to the strap defaults and clears mute and stop_flag.
- R10: A repeated byte that is not one of the eight command codes changes no setting and does not raise mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pdm_clk | input | 1 | PDM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, also used for clock loss |
| pdm_data | input | 1 | Shared PDM data line |
| lr_sel | input | 1 | Slot select: 1 = falling-edge slot, 0 = rising-edge slot |
| strap_gain | input | 1 | Default gain: 0 = 5 V, 1 = 3.6 V |
| strap_rate | input | 1 | Default rate: 0 = 64x, 1 = 128x |
| gain_sel | output | 2 | Active gain code |
| rate_sel | output | 1 | Active sample-rate select |
| low_emi | output | 1 | Low-emission modulation flag |
| half_pulse | output | 1 | Half-cycle pulse mode flag |
| special_rate | output | 1 | Special low-rate 128x mode flag |
| mute | output | 1 | Output mute request |
| stop_flag | output | 1 | Stop command in force |

## Verification
The hardest case to reach from the ports is a run boundary where one command is followed directly by another. At that edge the mute hold, the relock with a count of one and the clearing of the old run must all happen together, and each state needs over a thousand bit clocks of repeats to build up. The bench drives byte-synchronous streams that stop one byte short of and exactly at 128 repeats. It switches commands at an exact byte boundary and breaks a run with a single stray byte. It also offsets a stream by three bits to prove that the window realigns. The part of the sweep that covers every command and every strap combination checks each one against an expected value computed from the command code.

// File: rtl/pdm_cmd_pkg.sv
package pdm_cmd_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_STOP      = 8'hAC;
  localparam logic [CMD_W-1:0] CMD_GAIN_HI   = 8'hD8;
  localparam logic [CMD_W-1:0] CMD_GAIN_MID  = 8'hD4;
  localparam logic [CMD_W-1:0] CMD_GAIN_LO   = 8'hD2;
  localparam logic [CMD_W-1:0] CMD_RATE_FLIP = 8'hD1;
  localparam logic [CMD_W-1:0] CMD_LOW_EMI   = 8'hE1;
  localparam logic [CMD_W-1:0] CMD_HALF      = 8'hE2;
  localparam logic [CMD_W-1:0] CMD_SPECIAL   = 8'hE4;

  typedef enum logic [1:0] {
    GAIN_5V0 = 2'b00,
    GAIN_3V6 = 2'b01,
    GAIN_2V5 = 2'b10
  } gain_e;

  function automatic logic is_command(input logic [CMD_W-1:0] b);
    return b inside {CMD_STOP, CMD_GAIN_HI, CMD_GAIN_MID, CMD_GAIN_LO,
                     CMD_RATE_FLIP, CMD_LOW_EMI, CMD_HALF, CMD_SPECIAL};
  endfunction
endpackage

// File: rtl/pdm_reset_sync.sv
module pdm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= 1'b0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdm_slot_capture.sv
module pdm_slot_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pdm_data,
  input  logic lr_sel,
  output logic bit_o
);
  logic fall_q;

  // falling-edge slot, held for use at the following rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= pdm_data;
  end

  // rising-edge slot is taken straight from the line at the rising edge
  always_comb begin
    bit_o = lr_sel ? fall_q : pdm_data;
  end
endmodule

// File: rtl/pdm_pattern_tracker.sv
module pdm_pattern_tracker
  import pdm_cmd_pkg::*;
#(
  parameter int REPEAT  = 128,
  parameter int MUTE_AT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  output logic             apply_o,
  output logic             run_end_o,
  output logic [CMD_W-1:0] code_o,
  output logic             mute_o
);
  localparam int CNT_W  = $clog2(REPEAT + 1);
  localparam int PH_W   = $clog2(CMD_W);
  localparam int HOLD_W = $clog2(CMD_W + 1);

  logic [CMD_W-1:0]  shift_q, shift_d;
  logic              locked_q, locked_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CMD_W-1:0]  code_q, code_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              mute_q, mute_d;
  logic              at_boundary, same, fresh, apply, run_end;

  always_comb begin
    shift_d     = {shift_q[CMD_W-2:0], bit_i};
    at_boundary = locked_q && (phase_q == PH_W'(CMD_W - 1));
    same        = (shift_d == code_q);
    fresh       = is_command(shift_d);

    locked_d = locked_q;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    code_d   = code_q;
    hold_d   = (hold_q != '0) ? hold_q - 1'b1 : hold_q;
    apply    = 1'b0;
    run_end  = 1'b0;

    if (!locked_q) begin
      // search every bit position until a command byte appears
      if (fresh) begin
        locked_d = 1'b1;
        phase_d  = '0;
        cnt_d    = CNT_W'(1);
        code_d   = shift_d;
      end
    end else if (at_boundary) begin
      phase_d = '0;
      if (same) begin
        if (cnt_q != CNT_W'(REPEAT)) cnt_d = cnt_q + 1'b1;
        apply = (cnt_q == CNT_W'(REPEAT - 1));
      end else begin
        run_end = 1'b1;
        if (cnt_q >= CNT_W'(MUTE_AT)) hold_d = HOLD_W'(CMD_W);
        if (fresh) begin
          code_d = shift_d;
          cnt_d  = CNT_W'(1);
        end else begin
          locked_d = 1'b0;
          cnt_d    = '0;
        end
      end
    end else begin
      phase_d = phase_q + 1'b1;
    end

    mute_d = (cnt_d >= CNT_W'(MUTE_AT)) || (hold_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      locked_q <= 1'b0;
      phase_q  <= '0;
      cnt_q    <= '0;
      code_q   <= '0;
      hold_q   <= '0;
      mute_q   <= 1'b0;
    end else begin
      shift_q  <= shift_d;
      locked_q <= locked_d;
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      code_q   <= code_d;
      hold_q   <= hold_d;
      mute_q   <= mute_d;
    end
  end

  assign apply_o   = apply;
  assign run_end_o = run_end;
  assign code_o    = code_q;
  assign mute_o    = mute_q;

  // R8: an idle tracker carries no repeat count
  p_idle_count_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> (cnt_q == '0));

  // R8: a stray non-command byte at a boundary drops the lock and the count
  p_break_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && !same && !fresh) |=> (!locked_q && cnt_q == '0));

  // R7: settings are only written while mute is already up
  p_apply_muted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> mute_q);

  // R7: mute only falls when the post-run hold runs out
  p_release_after_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_q) |-> ($past(hold_q) == HOLD_W'(1)));
endmodule

// File: rtl/pdm_setting_reg.sv
module pdm_setting_reg
  import pdm_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply_i,
  input  logic             run_end_i,
  input  logic [CMD_W-1:0] code_i,
  input  logic             strap_gain_i,
  input  logic             strap_rate_i,
  output logic [1:0]       gain_o,
  output logic             rate_o,
  output logic             low_emi_o,
  output logic             half_pulse_o,
  output logic             special_o,
  output logic             stop_o
);
  logic  gain_ovr_q, gain_ovr_d;
  gain_e gain_q, gain_d;
  logic  flip_q, flip_d;
  logic  emi_q, emi_d;
  logic  half_q, half_d;
  logic  spec_q, spec_d;
  logic  stop_q, stop_d;
  gain_e strap_gain_val;

  always_comb begin
    gain_ovr_d = gain_ovr_q;
    gain_d     = gain_q;
    flip_d     = flip_q;
    emi_d      = emi_q;
    half_d     = half_q;
    spec_d     = spec_q;
    stop_d     = stop_q;
    if (apply_i) begin
      case (code_i)
        CMD_GAIN_HI:   begin gain_ovr_d = 1'b1; gain_d = GAIN_5V0; end
        CMD_GAIN_MID:  begin gain_ovr_d = 1'b1; gain_d = GAIN_3V6; end
        CMD_GAIN_LO:   begin gain_ovr_d = 1'b1; gain_d = GAIN_2V5; end
        CMD_RATE_FLIP: flip_d = 1'b1;
        CMD_LOW_EMI:   emi_d  = 1'b1;
        CMD_HALF:      half_d = 1'b1;
        CMD_SPECIAL:   spec_d = 1'b1;
        CMD_STOP:      stop_d = 1'b1;
        default:       ;
      endcase
    end else if (run_end_i) begin
      stop_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_ovr_q <= 1'b0;
      gain_q     <= GAIN_5V0;
      flip_q     <= 1'b0;
      emi_q      <= 1'b0;
      half_q     <= 1'b0;
      spec_q     <= 1'b0;
      stop_q     <= 1'b0;
    end else begin
      gain_ovr_q <= gain_ovr_d;
      gain_q     <= gain_d;
      flip_q     <= flip_d;
      emi_q      <= emi_d;
      half_q     <= half_d;
      spec_q     <= spec_d;
      stop_q     <= stop_d;
    end
  end

  always_comb begin
    strap_gain_val = strap_gain_i ? GAIN_3V6 : GAIN_5V0;
    gain_o         = gain_ovr_q ? gain_q : strap_gain_val;
    rate_o         = strap_rate_i ^ flip_q;
    low_emi_o      = emi_q;
    half_pulse_o   = half_q;
    special_o      = spec_q;
    stop_o         = stop_q;
  end

  // R2: once a gain code has taken effect the override persists
  p_override_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gain_ovr_q |=> gain_ovr_q);

  // R4: mode flags are sticky until reset
  p_flags_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (emi_q || half_q || spec_q) |=> ((emi_q || !$past(emi_q)) &&
                                     (half_q || !$past(half_q)) &&
                                     (spec_q || !$past(spec_q))));

  // R5: the stop flag only rises on a completed stop run
  p_stop_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> ($past(apply_i) && $past(code_i) == CMD_STOP));

  // R5: the stop flag only falls when the run ends
  p_stop_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_q) |-> $past(run_end_i));
endmodule

// File: rtl/pdm_pattern_detector.sv
module pdm_pattern_detector
  import pdm_cmd_pkg::*;
#(
  parameter int REPEAT      = 128,
  parameter int MUTE_AT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       pdm_clk,
  input  logic       rst_n,
  input  logic       pdm_data,
  input  logic       lr_sel,
  input  logic       strap_gain,
  input  logic       strap_rate,
  output logic [1:0] gain_sel,
  output logic       rate_sel,
  output logic       low_emi,
  output logic       half_pulse,
  output logic       special_rate,
  output logic       mute,
  output logic       stop_flag
);
  logic             rst_sync_n;
  logic             slot_bit;
  logic             apply;
  logic             run_end;
  logic [CMD_W-1:0] run_code;

  pdm_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (pdm_clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  pdm_slot_capture u_slot (
    .clk      (pdm_clk),
    .rst_n    (rst_sync_n),
    .pdm_data (pdm_data),
    .lr_sel   (lr_sel),
    .bit_o    (slot_bit)
  );

  pdm_pattern_tracker #(.REPEAT(REPEAT), .MUTE_AT(MUTE_AT)) u_track (
    .clk       (pdm_clk),
    .rst_n     (rst_sync_n),
    .bit_i     (slot_bit),
    .apply_o   (apply),
    .run_end_o (run_end),
    .code_o    (run_code),
    .mute_o    (mute)
  );

  pdm_setting_reg u_cfg (
    .clk          (pdm_clk),
    .rst_n        (rst_sync_n),
    .apply_i      (apply),
    .run_end_i    (run_end),
    .code_i       (run_code),
    .strap_gain_i (strap_gain),
    .strap_rate_i (strap_rate),
    .gain_o       (gain_sel),
    .rate_o       (rate_sel),
    .low_emi_o    (low_emi),
    .half_pulse_o (half_pulse),
    .special_o    (special_rate),
    .stop_o       (stop_flag)
  );

  // R1: a completed run never coincides with a boundary that ends it
  p_apply_exclusive_r1: assert property (@(posedge pdm_clk) disable iff (!rst_sync_n)
    !(apply && run_end));
endmodule

// File: tb/pdm_pattern_detector_test.sv
module pdm_pattern_detector_test;
  logic       pdm_clk = 1'b0;
  logic       rst_n;
  logic       pdm_data;
  logic       lr_sel;
  logic       strap_gain;
  logic       strap_rate;
  logic [1:0] gain_sel;
  logic       rate_sel, low_emi, half_pulse, special_rate, mute, stop_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 pdm_clk = ~pdm_clk;

  pdm_pattern_detector uut (
    .pdm_clk(pdm_clk), .rst_n(rst_n), .pdm_data(pdm_data), .lr_sel(lr_sel),
    .strap_gain(strap_gain), .strap_rate(strap_rate), .gain_sel(gain_sel),
    .rate_sel(rate_sel), .low_emi(low_emi), .half_pulse(half_pulse),
    .special_rate(special_rate), .mute(mute), .stop_flag(stop_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_settings(input string tag, input int eg, input int er,
                                input int ee, input int eh, input int es);
    check({tag, " gain"}, int'(gain_sel), eg);
    check({tag, " rate"}, int'(rate_sel), er);
    check({tag, " low_emi"}, int'(low_emi), ee);
    check({tag, " half_pulse"}, int'(half_pulse), eh);
    check({tag, " special"}, int'(special_rate), es);
  endtask

  // one bit period: right slot before the falling edge, left before the rising
  task automatic step(input logic l, input logic r);
    pdm_data = r;
    @(negedge pdm_clk); #2;
    pdm_data = l;
    @(posedge pdm_clk); #2;
  endtask

  task automatic send_byte(input logic [7:0] l, input logic [7:0] r);
    for (int i = 7; i >= 0; i--) step(l[i], r[i]);
  endtask

  task automatic send_left(input logic [7:0] b, input int n);
    for (int k = 0; k < n; k++) send_byte(b, 8'h00);
  endtask

  task automatic do_reset(input logic sg, input logic sr);
    rst_n = 1'b0;
    pdm_data = 1'b0;
    strap_gain = sg;
    strap_rate = sr;
    repeat (3) @(posedge pdm_clk);
    #2;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
  endtask

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      8'hAC: return "R5";
      8'hD8, 8'hD4, 8'hD2: return "R2";
      8'hD1: return "R3";
      8'hE1, 8'hE2, 8'hE4: return "R4";
      default: return "R10";
    endcase
  endfunction

  function automatic bit is_cmd(input logic [7:0] c);
    return c inside {8'hAC, 8'hD8, 8'hD4, 8'hD2, 8'hD1, 8'hE1, 8'hE2, 8'hE4};
  endfunction

  logic [7:0] codes [9] = '{8'hAC, 8'hD8, 8'hD4, 8'hD2, 8'hD1, 8'hE1, 8'hE2, 8'hE4, 8'h33};

  initial begin
    repeat (150000) @(posedge pdm_clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    lr_sel = 1'b0;
    rst_n = 1'b0;
    pdm_data = 1'b0;
    strap_gain = 1'b0;
    strap_rate = 1'b0;
    @(posedge pdm_clk); #2;

    // sweep: every strap combination against every command and one non-command
    for (int sg = 0; sg < 2; sg++) begin
      for (int sr = 0; sr < 2; sr++) begin
        for (int ci = 0; ci < 9; ci++) begin
          logic [7:0] c;
          int dg, eg, er, ee, eh, es, cm;
          string t;
          c  = codes[ci];
          t  = tag_of(c);
          cm = is_cmd(c) ? 1 : 0;
          dg = sg;
          do_reset(sg[0], sr[0]);
          // R9: defaults after reset
          check_settings("R9", dg, sr, 0, 0, 0);
          check("R9 mute", int'(mute), 0);
          check("R9 stop", int'(stop_flag), 0);

          send_left(c, 7);
          check("R7 mute after 7", int'(mute), 0);
          send_left(c, 1);
          check("R7 mute after 8", int'(mute), cm);
          send_left(c, 119);
          // R1: 127 repeats leave settings untouched
          check_settings("R1", dg, sr, 0, 0, 0);
          check("R1 stop", int'(stop_flag), 0);
          send_left(c, 1);

          eg = (c == 8'hD8) ? 0 : (c == 8'hD4) ? 1 : (c == 8'hD2) ? 2 : dg;
          er = (c == 8'hD1) ? 1 - sr : sr;
          ee = (c == 8'hE1) ? 1 : 0;
          eh = (c == 8'hE2) ? 1 : 0;
          es = (c == 8'hE4) ? 1 : 0;
          check_settings(t, eg, er, ee, eh, es);
          check({t, " stop"}, int'(stop_flag), (c == 8'hAC) ? 1 : 0);
          check("R10 mute level", int'(mute), cm);

          // end of run
          send_left(8'h00, 1);
          check("R5 stop cleared", int'(stop_flag), 0);
          check("R7 mute held", int'(mute), cm);
          for (int i = 0; i < 7; i++) step(1'b0, 1'b0);
          check("R7 mute held 7", int'(mute), cm);
          step(1'b0, 1'b0);
          check("R7 mute released", int'(mute), 0);
          check_settings({t, " persist"}, eg, er, ee, eh, es);
        end
      end
    end

    // R6: falling-edge slot decoded with lr_sel high
    lr_sel = 1'b1;
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 128; k++) send_byte(8'h00, 8'hD2);
    check("R6 right slot gain", int'(gain_sel), 2);
    check("R6 right slot mute", int'(mute), 1);
    // R6: rising-edge slot ignored with lr_sel high
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 128; k++) send_byte(8'hE2, 8'h00);
    check("R6 left ignored", int'(half_pulse), 0);
    check("R6 left ignored mute", int'(mute), 0);
    // R6: falling-edge slot ignored with lr_sel low
    lr_sel = 1'b0;
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 128; k++) send_byte(8'h00, 8'hE1);
    check("R6 right ignored", int'(low_emi), 0);
    check("R6 right ignored mute", int'(mute), 0);

    // R8: stream starting three bits off a byte edge
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    send_left(8'hD4, 127);
    check("R8 offset 127", int'(gain_sel), 0);
    send_left(8'hD4, 1);
    check("R8 offset 128", int'(gain_sel), 1);

    // R8: a stray byte restarts the count
    do_reset(1'b1, 1'b0);
    send_left(8'hD8, 100);
    send_left(8'h00, 1);
    send_left(8'hD8, 127);
    check("R8 break 127", int'(gain_sel), 1);
    send_left(8'hD8, 1);
    check("R8 break 128", int'(gain_sel), 0);

    // R8: a new command at the boundary starts its own run at one
    do_reset(1'b0, 1'b0);
    send_left(8'hE1, 100);
    send_left(8'hD4, 1);
    check("R8 switch mute", int'(mute), 1);
    send_left(8'hD4, 126);
    check("R8 switch 127 gain", int'(gain_sel), 0);
    check("R8 switch low_emi", int'(low_emi), 0);
    send_left(8'hD4, 1);
    check("R8 switch 128 gain", int'(gain_sel), 1);

    // R3: a second rate run does not toggle back
    do_reset(1'b0, 1'b1);
    send_left(8'hD1, 128);
    check("R3 first run", int'(rate_sel), 0);
    send_left(8'h00, 1);
    send_left(8'hD1, 128);
    check("R3 second run", int'(rate_sel), 0);

    // R9: reset after commands restores defaults
    do_reset(1'b0, 1'b1);
    check_settings("R9 after runs", 0, 1, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule